// File: doc/BRIEF.md
# Burst-Chain Locking Read Arbiter

This block shares one memory read port among several display scanout channels. Each channel raises a request while it wants data and pulses a per-channel completion input each time one of its bursts (up to 64 bytes) has been served. A memory controller with shallow queues performs best when back-to-back bursts fall on consecutive addresses. For that reason the arbiter does not rotate after every burst. Once a channel wins, it holds the grant for a chain of consecutive bursts whose length is programmed for that channel. Only then does the grant move on.

Chain length is set per channel by a 2-bit code written through a small write port. A separate per-channel input marks channels that fetch a separate alpha plane. Those channels interleave two address streams, so chaining gives them no benefit and they are always served one burst per grant. Between chains the next holder is chosen round-robin. The search starts at the channel after the one that last won. When a chain ends and another channel is requesting, the grant moves to it at the same clock edge, with no idle cycle in between.

Top module: `burst_lock_arb`

## Requirements
- R1: `grant_o` is either all zero or has exactly one bit set.
- R2: A grant is registered. A channel whose request is seen at a clock edge while no chain is active gets its grant bit set at that edge. Only a channel that was requesting at that edge can receive a new grant.
- R3: The lock code selects the chain length: code 0 gives 1 burst, code 1 gives 2, code 2 gives 4 and code 3 gives 8. The holder keeps the grant until that many of its own completion pulses have been counted.
- R4: With code 0, a channel gets one burst per grant. After that burst, the grant passes to the next requesting channel.
- R5: While `sep_alpha_i[i]` is high when channel i is granted, its chain is one burst long, whatever its code.
- R6: If the holder's request is low at a clock edge, its grant is removed at that edge even if the chain has not finished.
- R7: The next holder is the first requesting channel found by scanning upward, with wrap-around, from the channel after the previous holder.
- R8: A lock code written while a chain is running does not change that chain. It takes effect the next time the channel is granted.
- R9: Completion pulses from channels that do not hold the grant, or pulses arriving while nothing is granted, change nothing.
- R10: After reset, no grant is held and all lock codes are 0. The first scan begins at channel 0.
- R11: When a chain ends and other channels are requesting, the new grant appears at the same edge that ends the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | NUM_CH | Per-channel read request |
| done_i | input | NUM_CH | Per-channel burst completion pulse |
| sep_alpha_i | input | NUM_CH | Channel fetches a separate alpha plane (forces one-burst chains) |
| cfg_we_i | input | 1 | Lock code write strobe |
| cfg_ch_i | input | CH_W | Channel whose lock code is written |
| cfg_code_i | input | 2 | Lock code: 0=1, 1=2, 2=4, 3=8 bursts |
| grant_o | output | NUM_CH | One-hot grant |

## Verification
Each chain length is run with two competing channels. The completion pulse on which the grant moves shows whether the code was decoded correctly, and whether a chain is cut short or runs too long. Four channels all requesting with code 0 check the rotation order, and a pattern with a gap checks that non-requesting channels are skipped. Further cases cover a request dropped in mid-chain, stray completion pulses from other channels, a code rewritten during a chain, and the alpha override. Together these separate early release, counter reloading and the moment the configuration is sampled.

// File: rtl/burst_lock_pkg.sv
package burst_lock_pkg;
    localparam int LOCK_CODE_W = 2;
    localparam int LOCK_CNT_W  = 4;   // holds the longest chain (8)

    function automatic logic [LOCK_CNT_W-1:0] chain_len(
        input logic [LOCK_CODE_W-1:0] code,
        input logic                   sep_alpha
    );
        if (sep_alpha) return LOCK_CNT_W'(1);
        return LOCK_CNT_W'(1) << code;
    endfunction
endpackage

// File: rtl/lock_cfg_bank.sv
module lock_cfg_bank
    import burst_lock_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we_i,
    input  logic [CH_W-1:0]                     sel_i,
    input  logic [LOCK_CODE_W-1:0]              code_i,
    output logic [NUM_CH-1:0][LOCK_CODE_W-1:0]  code_o
);
    logic [NUM_CH-1:0][LOCK_CODE_W-1:0] code_d, code_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        always_comb begin
            code_d[g] = code_q[g];
            if (we_i && sel_i == CH_W'(g)) code_d[g] = code_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) code_q[g] <= '0;
            else        code_q[g] <= code_d[g];
        end
    end

    assign code_o = code_q;
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req_i,
    input  logic [CH_W-1:0]   last_i,
    output logic              valid_o,
    output logic [CH_W-1:0]   idx_o
);
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int off = 1; off <= NUM_CH; off++) begin
            int cand;
            cand = (int'(last_i) + off) % NUM_CH;
            if (!valid_o && req_i[cand]) begin
                valid_o = 1'b1;
                idx_o   = CH_W'(cand);
            end
        end
    end
endmodule

// File: rtl/burst_lock_arb.sv
module burst_lock_arb
    import burst_lock_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CH-1:0]      req_i,
    input  logic [NUM_CH-1:0]      done_i,
    input  logic [NUM_CH-1:0]      sep_alpha_i,
    input  logic                   cfg_we_i,
    input  logic [CH_W-1:0]        cfg_ch_i,
    input  logic [LOCK_CODE_W-1:0] cfg_code_i,
    output logic [NUM_CH-1:0]      grant_o
);
    typedef struct packed {
        logic [NUM_CH-1:0]     grant;
        logic [LOCK_CNT_W-1:0] cnt;
        logic [CH_W-1:0]       last;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NUM_CH-1:0][LOCK_CODE_W-1:0] code;
    logic              pick_valid;
    logic [CH_W-1:0]   pick_idx;
    logic              busy, own_req, own_done, chain_end, release_now;

    lock_cfg_bank #(.NUM_CH(NUM_CH)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we_i),
        .sel_i  (cfg_ch_i),
        .code_i (cfg_code_i),
        .code_o (code)
    );

    rr_pick #(.NUM_CH(NUM_CH)) u_pick (
        .req_i   (req_i),
        .last_i  (st_q.last),
        .valid_o (pick_valid),
        .idx_o   (pick_idx)
    );

    always_comb begin
        busy        = |st_q.grant;
        own_req     = |(st_q.grant & req_i);
        own_done    = |(st_q.grant & done_i);
        chain_end   = own_done && (st_q.cnt == LOCK_CNT_W'(1));
        release_now = busy && (!own_req || chain_end);

        st_d = st_q;
        if (busy && !release_now && own_done) begin
            st_d.cnt = st_q.cnt - LOCK_CNT_W'(1);
        end
        if (!busy || release_now) begin
            st_d.grant = '0;
            st_d.cnt   = '0;
            if (pick_valid) begin
                st_d.grant[pick_idx] = 1'b1;
                st_d.cnt  = chain_len(code[pick_idx], sep_alpha_i[pick_idx]);
                st_d.last = pick_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.grant <= '0;
            st_q.cnt   <= '0;
            st_q.last  <= CH_W'(NUM_CH - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o = st_q.grant;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R1

    AST_NEW_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o != $past(grant_o)) && (|grant_o)) |-> (|(grant_o & $past(req_i)))); // R2

    AST_CHAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant_o) && (|(grant_o & req_i)) &&
         !((|(grant_o & done_i)) && st_q.cnt == LOCK_CNT_W'(1))) |=> $stable(grant_o)); // R3

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o) |-> (st_q.cnt != '0 && st_q.cnt <= LOCK_CNT_W'(8))); // R3

    AST_DROP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant_o) && !(|(grant_o & req_i))) |=> ((grant_o & $past(grant_o)) == '0)); // R6
endmodule

// File: tb/burst_lock_arb_bench.sv
module burst_lock_arb_bench;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0, done = '0, sep = '0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_ch = '0, cfg_code = '0;
    logic [3:0] grant;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    burst_lock_arb #(.NUM_CH(N)) u_burst_lock_arb (
        .clk(clk), .rst_n(rst_n), .req_i(req), .done_i(done),
        .sep_alpha_i(sep), .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch),
        .cfg_code_i(cfg_code), .grant_o(grant)
    );

    task automatic chk(input string tag, input logic [3:0] exp);
        total++;
        if (grant !== exp) begin
            bad++;
            $display("FAIL %s grant=%b expected=%b", tag, grant, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req = '0; done = '0; sep = '0; cfg_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_code(input int ch, input int code);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_code = 2'(code);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse(input int ch);
        done = 4'b0001 << ch;
        @(negedge clk);
        done = '0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R10 reset no grant", 4'b0000);
        pulse(0); pulse(2);
        chk("R9 done while idle", 4'b0000);
    endtask

    task automatic t_basic();
        do_reset();
        set_code(0, 2);
        req = 4'b0011;
        step();
        chk("R10 first scan from ch0 / R2", 4'b0001);
        for (int k = 0; k < 3; k++) begin
            pulse(0);
            chk("R3 four-burst chain holds", 4'b0001);
        end
        pulse(1);
        chk("R9 foreign done ignored", 4'b0001);
        pulse(0);
        chk("R11 handoff at chain end / R7", 4'b0010);
        pulse(1);
        chk("R4 code0 one burst per grant", 4'b0001);
    endtask

    task automatic t_len(input int code);
        do_reset();
        set_code(2, code);
        req = 4'b1100;
        step();
        chk("R2 grant to ch2", 4'b0100);
        for (int k = 0; k < (1 << code) - 1; k++) begin
            pulse(2);
            chk("R3 chain not yet done", 4'b0100);
        end
        pulse(2);
        chk("R3 chain length exact", 4'b1000);
    endtask

    task automatic t_alpha();
        do_reset();
        set_code(2, 3);
        sep = 4'b0100;
        req = 4'b1100;
        step();
        chk("R5 grant ch2", 4'b0100);
        pulse(2);
        chk("R5 alpha channel single burst", 4'b1000);
    endtask

    task automatic t_drop();
        do_reset();
        set_code(0, 3);
        req = 4'b0101;
        step();
        chk("R2 grant ch0", 4'b0001);
        pulse(0);
        req = 4'b0100;
        step();
        chk("R6 early release on drop", 4'b0100);
        req = 4'b0000;
        step();
        chk("R6 release with no requester", 4'b0000);
    endtask

    task automatic t_rr();
        logic [3:0] seq [5];
        seq[0] = 4'b0001; seq[1] = 4'b0010; seq[2] = 4'b0100;
        seq[3] = 4'b1000; seq[4] = 4'b0001;
        do_reset();
        req = 4'b1111;
        step();
        for (int k = 0; k < 5; k++) begin
            chk("R7 rotation order", seq[k]);
            total++;
            if ($countones(grant) > 1) begin
                bad++;
                $display("FAIL R1 grant=%b expected=onehot", grant);
            end
            pulse(k % 4);
        end
        req = 4'b1011;
        chk("R7 ch1 holds", 4'b0010);
        pulse(1);
        chk("R7 skip idle ch2", 4'b1000);
    endtask

    task automatic t_cfg_mid();
        do_reset();
        set_code(0, 3);
        req = 4'b0011;
        step();
        chk("R8 grant ch0", 4'b0001);
        set_code(0, 0);
        for (int k = 0; k < 7; k++) pulse(0);
        chk("R8 running chain keeps old length", 4'b0001);
        pulse(0);
        chk("R8 chain of eight ends", 4'b0010);
        pulse(1);
        chk("R8 back to ch0", 4'b0001);
        pulse(0);
        chk("R8 new code used at next grant", 4'b0010);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_len(1);
        t_len(3);
        t_len(0);
        t_alpha();
        t_drop();
        t_rr();
        t_cfg_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog grant=%b expected=finished run", grant);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule